// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block takes a set of sixteen per-thread memory requests, each with a byte address, an element size and an active flag. It turns them into a short series of aligned memory transactions. Each transaction carries an aligned base address, a segment size of 32, 64 or 128 bytes, and a sixteen-bit mask. The mask names the threads that the transaction serves.

Work is done one pass at a time. Each pass starts from the lowest-numbered thread that is still waiting. The leader's element size picks an initial segment. Every other waiting thread whose address falls in that aligned segment joins the pass. The segment is then narrowed to the smallest aligned half that still holds every joined address. The block offers each transaction with a valid/ready handshake and retires the joined threads when the transaction is taken. When no thread remains, it signals completion with a one-cycle pulse. A new request set is taken only while the block is idle.

Addresses are expected to be naturally aligned to their element size, so every byte of an element shares the address bits above bit 4.

Top module: `coal_halfwarp`

## Requirements
- R1: After reset, `req_ready` is 1, `txn_valid` is 0 and `done` is 0.
- R2: A request set is captured only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is 0 from the cycle after capture of a set with at least one active thread until the cycle after its last transaction is accepted. `req_valid` and request data applied while `req_ready` is 0 do not alter the transactions issued.
- R3: Each transaction's mask contains the lowest-numbered pending thread. Its starting segment comes from that thread's `req_elem_size` code: 0 (1 byte) gives 32 bytes, 1 (2 bytes) gives 64 bytes, and 2 (4 bytes) or 3 (8 bytes) give 128 bytes.
- R4: Every pending thread whose address lies in the leader's aligned starting segment is set in that transaction's mask. No other thread is set.
- R5: Narrowing works in two steps. If all joined addresses share address bit 6, a 128-byte segment becomes 64 bytes. If a 64-byte segment's joined addresses then share bit 5, it becomes 32 bytes. `txn_base` is the leader address with the bits below the final size cleared. `txn_size` codes the final size: 0 is 32 bytes, 1 is 64 bytes, 2 is 128 bytes.
- R6: Threads in an accepted transaction's mask are never served again. Every active thread is served exactly once.
- R7: A thread whose `req_active` bit is 0 at capture appears in no transaction mask.
- R8: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid`, `txn_base`, `txn_size` and `txn_mask` hold their values into the next cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the last transaction is accepted. For a set with no active thread, it is high in the cycle after capture, and no transaction is issued.
- R10: Sixteen active threads in one 128-byte segment produce exactly one transaction. Sixteen threads in sixteen distinct segments produce exactly sixteen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request set offered |
| req_ready | output | 1 | Block idle, able to capture a set |
| req_active | input | NTHR | Per-thread active flag |
| req_addr | input | NTHR*AW | Per-thread byte address, thread i at bits [i*AW +: AW] |
| req_elem_size | input | 2*NTHR | Per-thread element size code, thread i at bits [2i +: 2] |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction accepted when high with txn_valid |
| txn_base | output | AW | Aligned segment base |
| txn_size | output | 2 | Segment size code |
| txn_mask | output | NTHR | Threads served by this transaction |
| done | output | 1 | One-cycle pulse when the set is fully served |

## Verification
The patterns tried are all threads in one segment, all threads in distinct segments, and byte-wide accesses packed in 32 bytes. These separate the one-transaction and sixteen-transaction extremes and show that the starting segment follows the leader's element size. Clustered addresses inside a 32-byte or 64-byte window exercise each narrowing step. Interleaved segments show that the passes follow leader order rather than address order. Scattered inactive threads, mixed element sizes and an empty set cover exclusion, per-leader segment choice and the completion pulse with no traffic. Stalled acceptance and requests arriving while busy show that the offered transaction holds and that late requests are ignored.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    SEG_32B  = 2'd0,
    SEG_64B  = 2'd1,
    SEG_128B = 2'd2
  } seg_e;

  // Starting segment chosen from the leader's element-size code.
  function automatic seg_e seg_for_elem(input logic [1:0] esz);
    case (esz)
      2'd0:    return SEG_32B;
      2'd1:    return SEG_64B;
      default: return SEG_128B;
    endcase
  endfunction

  // Narrow a segment while all served addresses share the next address bit.
  function automatic seg_e seg_shrink(input seg_e s, input logic same64,
                                      input logic same32);
    seg_e r;
    r = s;
    if (r == SEG_128B && same64) r = SEG_64B;
    if (r == SEG_64B && same32)  r = SEG_32B;
    return r;
  endfunction

endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
  parameter int NTHR = 16,
  localparam int IW = $clog2(NTHR)
) (
  input  logic [NTHR-1:0] pend,
  output logic            found,
  output logic [IW-1:0]   idx,
  output logic [NTHR-1:0] onehot
);
  // Lowest set bit wins: scan from the top down so lower indices overwrite.
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = NTHR - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
    onehot = found ? (NTHR'(1) << idx) : '0;
  end
endmodule

// File: rtl/coal_match.sv
module coal_match
  import coal_pkg::*;
#(
  parameter int NTHR = 16,
  parameter int AW   = 32
) (
  input  logic [NTHR*AW-1:0] addr,
  input  logic [NTHR-1:0]    pend,
  input  logic [AW-1:0]      lead_addr,
  input  seg_e               seg0,
  output logic [NTHR-1:0]    hit,
  output logic               same64,
  output logic               same32
);
  logic [AW-1:0]   keep;
  logic [NTHR-1:0] eq6;
  logic [NTHR-1:0] eq5;

  always_comb begin
    case (seg0)
      SEG_32B: keep = {{(AW-5){1'b1}}, 5'b0};
      SEG_64B: keep = {{(AW-6){1'b1}}, 6'b0};
      default: keep = {{(AW-7){1'b1}}, 7'b0};
    endcase
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    logic [AW-1:0] a;
    assign a      = addr[g*AW +: AW];
    assign hit[g] = pend[g] && ((a & keep) == (lead_addr & keep));
    assign eq6[g] = (a[6] == lead_addr[6]);
    assign eq5[g] = (a[5] == lead_addr[5]);
  end

  assign same64 = &(~hit | eq6);
  assign same32 = &(~hit | eq5);
endmodule

// File: rtl/coal_halfwarp.sv
module coal_halfwarp
  import coal_pkg::*;
#(
  parameter int NTHR = 16,
  parameter int AW   = 32,
  localparam int IW = $clog2(NTHR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [NTHR-1:0]    req_active,
  input  logic [NTHR*AW-1:0] req_addr,
  input  logic [2*NTHR-1:0]  req_elem_size,
  output logic               txn_valid,
  input  logic               txn_ready,
  output logic [AW-1:0]      txn_base,
  output logic [1:0]         txn_size,
  output logic [NTHR-1:0]    txn_mask,
  output logic               done
);
  logic [NTHR*AW-1:0] addr_q;
  logic [2*NTHR-1:0]  esz_q;
  logic [NTHR-1:0]    pend_q;
  logic               busy_q;
  logic               done_q;

  // Named internal events
  logic            req_take;
  logic            txn_fire;
  logic            lead_found;
  logic [IW-1:0]   lead_idx;
  logic [NTHR-1:0] lead_onehot;
  logic [AW-1:0]   lead_addr;
  logic [1:0]      lead_esz;
  seg_e            seg_start;
  seg_e            seg_final;
  logic [NTHR-1:0] hit;
  logic            same64;
  logic            same32;
  logic [NTHR-1:0] pend_next;
  logic            last_fire;

  assign req_ready = !busy_q;
  assign req_take  = req_valid && req_ready;
  assign txn_valid = busy_q && lead_found;
  assign txn_fire  = txn_valid && txn_ready;

  coal_leader #(.NTHR(NTHR)) u_leader (
    .pend   (pend_q),
    .found  (lead_found),
    .idx    (lead_idx),
    .onehot (lead_onehot)
  );

  assign lead_addr = addr_q[lead_idx*AW +: AW];
  assign lead_esz  = esz_q[lead_idx*2 +: 2];
  assign seg_start = seg_for_elem(lead_esz);

  coal_match #(.NTHR(NTHR), .AW(AW)) u_match (
    .addr      (addr_q),
    .pend      (pend_q),
    .lead_addr (lead_addr),
    .seg0      (seg_start),
    .hit       (hit),
    .same64    (same64),
    .same32    (same32)
  );

  assign seg_final = seg_shrink(seg_start, same64, same32);

  always_comb begin
    case (seg_final)
      SEG_32B: txn_base = {lead_addr[AW-1:5], 5'b0};
      SEG_64B: txn_base = {lead_addr[AW-1:6], 6'b0};
      default: txn_base = {lead_addr[AW-1:7], 7'b0};
    endcase
  end

  assign txn_size  = seg_final;
  assign txn_mask  = hit;
  assign pend_next = pend_q & ~hit;
  assign last_fire = txn_fire && (pend_next == '0);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      esz_q  <= '0;
      pend_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (req_take && (req_active == '0)) || last_fire;
      if (req_take) begin
        addr_q <= req_addr;
        esz_q  <= req_elem_size;
        pend_q <= req_active;
        busy_q <= (req_active != '0);
      end else if (txn_fire) begin
        pend_q <= pend_next;
        if (pend_next == '0) busy_q <= 1'b0;
      end
    end
  end

  // Leader always served by its own transaction (R3)
  p_leader_in_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & lead_onehot) != '0));

  // Only pending threads can be served (R7)
  p_mask_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & ~pend_q) == '0));

  // Busy block refuses new sets (R2)
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  // Size code stays legal (R5)
  p_size_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_size != 2'd3));

  // Offer holds under back-pressure (R8)
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base)
                                   && $stable(txn_size) && $stable(txn_mask)));

  // Accepted transactions shrink the pending set (R6)
  p_progress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_fire && !req_take) |=> ($countones(pend_q) < $countones($past(pend_q))));

  // Last acceptance yields the done pulse (R9)
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_fire && ((pend_q & ~txn_mask) == '0)) |=> (done && !txn_valid));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/coal_halfwarp_tb.sv
module coal_halfwarp_tb;
  localparam int N  = 16;
  localparam int AW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [N-1:0]    req_active = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [2*N-1:0]  req_elem_size = '0;
  logic            txn_valid;
  logic            txn_ready = 1'b0;
  logic [AW-1:0]   txn_base;
  logic [1:0]      txn_size;
  logic [N-1:0]    txn_mask;
  logic            done;

  always #2 clk = ~clk;

  coal_halfwarp #(.NTHR(N), .AW(AW)) u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_active, .req_addr,
    .req_elem_size, .txn_valid, .txn_ready, .txn_base, .txn_size,
    .txn_mask, .done
  );

  int n_tests = 0;
  int n_fail  = 0;

  int unsigned a[N];
  int unsigned s[N];
  logic [N-1:0] act;

  int unsigned e_base[N];
  int unsigned e_code[N];
  logic [N-1:0] e_mask[N];
  int n_exp;

  task automatic chk(input bit ok, input string req, input string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Reference: byte-range model of the coalescing rules
  task automatic build_expected();
    logic [N-1:0] pend;
    pend = act;
    n_exp = 0;
    while (pend != 0) begin
      int lead, seg, lo, hi;
      logic [N-1:0] m;
      lead = 0;
      while (!pend[lead]) lead++;
      seg = (s[lead] == 0) ? 32 : (s[lead] == 1) ? 64 : 128;
      m = '0;
      lo = a[lead]; hi = a[lead];
      for (int j = 0; j < N; j++) begin
        if (pend[j] && (a[j] / seg == a[lead] / seg)) begin
          m[j] = 1'b1;
          if (a[j] < lo) lo = a[j];
          if (a[j] + (1 << s[j]) - 1 > hi) hi = a[j] + (1 << s[j]) - 1;
        end
      end
      while (seg > 32 && (lo / (seg / 2) == hi / (seg / 2))) seg = seg / 2;
      e_base[n_exp] = a[lead] / seg * seg;
      e_code[n_exp] = (seg == 32) ? 0 : (seg == 64) ? 1 : 2;
      e_mask[n_exp] = m;
      n_exp++;
      pend = pend & ~m;
    end
  endtask

  task automatic load_bus();
    for (int i = 0; i < N; i++) begin
      req_addr[i*AW +: AW]  = a[i];
      req_elem_size[2*i +: 2] = s[i][1:0];
    end
    req_active = act;
  endtask

  // stall: back-pressure pattern; poke: hold a second request while busy
  task automatic run_case(input string req, input bit stall, input bit poke);
    int k, cyc;
    bit held;
    logic [AW-1:0] hb; logic [1:0] hs; logic [N-1:0] hm;
    build_expected();
    @(negedge clk);
    load_bus();
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (n_exp == 0) begin
      chk(done === 1'b1 && txn_valid === 1'b0, req,
          $sformatf("empty set: done=%b valid=%b exp 1/0", done, txn_valid));
      @(negedge clk);
      chk(done === 1'b0 && req_ready === 1'b1, req, "done not single pulse");
      return;
    end
    if (poke) begin
      chk(req_ready === 1'b0, req, $sformatf("busy ready=%b exp 0", req_ready));
      for (int i = 0; i < N; i++) req_addr[i*AW +: AW] = 32'h9000 + 256 * i;
      req_active = '1;
    end
    k = 0; cyc = 0; held = 0; hb = '0; hs = '0; hm = '0;
    while (k < n_exp && cyc < 400) begin
      if (held)
        chk(txn_valid === 1'b1 && txn_base === hb && txn_size === hs && txn_mask === hm,
            "R8", $sformatf("stall hold base=%h size=%0d mask=%h exp %h %0d %h",
                            txn_base, txn_size, txn_mask, hb, hs, hm));
      txn_ready = stall ? (cyc % 3 == 2) : 1'b1;
      req_valid = poke && (k < n_exp - 1);
      if (!txn_valid) chk(0, req, "txn_valid low while work pending");
      else begin
        held = !txn_ready; hb = txn_base; hs = txn_size; hm = txn_mask;
        if (txn_ready) begin
          chk(txn_base === e_base[k] && txn_size === e_code[k][1:0] && txn_mask === e_mask[k],
              req, $sformatf("txn %0d base=%h size=%0d mask=%h exp %h %0d %h", k,
                             txn_base, txn_size, txn_mask, e_base[k], e_code[k], e_mask[k]));
          k++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    txn_ready = 1'b0;
    req_valid = 1'b0;
    chk(k == n_exp, req, $sformatf("count %0d exp %0d", k, n_exp));
    chk(done === 1'b1 && txn_valid === 1'b0, "R9",
        $sformatf("after last: done=%b valid=%b exp 1/0", done, txn_valid));
    @(negedge clk);
    chk(done === 1'b0 && req_ready === 1'b1, "R9", "done pulse longer than one cycle");
  endtask

  task automatic t_same_seg();   // R10 R4: one 128-byte transaction
    for (int i = 0; i < N; i++) begin a[i] = 32'h1000 + 4 * i; s[i] = 2; end
    act = '1;
    run_case("R10", 0, 0);
  endtask

  task automatic t_distinct();   // R10 R3: sixteen transactions
    for (int i = 0; i < N; i++) begin a[i] = 32'h2000 + 128 * (N - 1 - i); s[i] = 2; end
    act = '1;
    run_case("R10", 0, 0);
  endtask

  task automatic t_bytes();      // R3: byte elements use 32-byte segments
    for (int i = 0; i < N; i++) begin a[i] = 32'h3010 + i; s[i] = 0; end
    act = '1;
    run_case("R3", 0, 0);
  endtask

  task automatic t_shrink();     // R5: 32- and 64-byte narrowing
    for (int i = 0; i < 8; i++) begin a[i] = 32'h4040 + 4 * i; s[i] = 2; end
    for (int i = 8; i < N; i++) begin a[i] = 32'h5040 + 4 * i; s[i] = 2; end
    act = '1;
    run_case("R5", 0, 0);
    for (int i = 0; i < N; i++) begin a[i] = 32'h6040 + 4 * i; s[i] = 2; end
    run_case("R5", 0, 0);
  endtask

  task automatic t_inactive();   // R7
    for (int i = 0; i < N; i++) begin a[i] = 32'h7000 + 64 * i; s[i] = 2; end
    act = 16'h5A3C;
    run_case("R7", 0, 0);
  endtask

  task automatic t_interleave(); // R6 R4: passes follow leader order
    for (int i = 0; i < N; i++) begin
      a[i] = (i % 2) ? 32'h8000 + 4 * i : 32'h8800 + 4 * i; s[i] = 2;
    end
    act = '1;
    run_case("R6", 0, 0);
  endtask

  task automatic t_mixed();      // R3 R5: leader size picks the segment
    for (int i = 0; i < N; i++) begin a[i] = 32'hA000 + 256 * i; s[i] = 1; end
    a[0] = 32'hA000; s[0] = 1;
    a[1] = 32'hA038; s[1] = 3;
    a[2] = 32'hA040; s[2] = 2;
    a[3] = 32'hA07F; s[3] = 0;
    act = 16'h000F;
    run_case("R3", 0, 0);
  endtask

  task automatic t_stall_busy(); // R8 R2
    for (int i = 0; i < N; i++) begin a[i] = 32'hB000 + 32 * i; s[i] = 0; end
    act = '1;
    run_case("R2", 1, 1);
  endtask

  task automatic t_empty();      // R9
    act = '0;
    run_case("R9", 0, 0);
  endtask

  initial begin
    #1;
    chk(req_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0, "R1",
        $sformatf("in reset ready=%b valid=%b done=%b exp 1/0/0", req_ready, txn_valid, done));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0, "R1",
        $sformatf("after reset ready=%b valid=%b done=%b exp 1/0/0", req_ready, txn_valid, done));
    t_same_seg();
    t_distinct();
    t_bytes();
    t_shrink();
    t_inactive();
    t_interleave();
    t_mixed();
    t_stall_busy();
    t_empty();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule